// File: doc/BRIEF.md
# Sharing-State Gated Access Controller

This block sits beside a group of cores that run deterministic quanta in parallel. On every cycle it looks at each core's pending memory access, the coherence state of the target line in that core's cache, whether another core holds the line privately, and whether the core holds the deterministic token. From these it decides whether the access may proceed at once, in the communication-free parallel part of the quantum, or must wait until the machine has drained into serial execution.

An access that cannot communicate with another thread (any access to a line held privately, or a read of a line that nobody holds privately) is granted in the same cycle. An access that would communicate (a write to a line that is not private, or a read of a line another core owns privately) is only granted to the token holder, and only when every other core is blocked, either on such an access of its own or at the end of its quantum. Once such an access has been granted, the core stays in serial mode for the remainder of its quantum, so all its later accesses follow the same rule. The block also reports when every core is blocked, the point at which the machine may switch from parallel to serial execution.

Top module: `sgac_gate_ctrl`

## Requirements
- R1: An access to a line whose local state is Exclusive (2'd2) or Modified (2'd3) is granted in the same cycle without the token, whatever the remote-private flag, when the core is not in serial mode and not at a quantum end.
- R2: A read (write flag 0) of a line in Invalid (2'd0) or Shared (2'd1) state with the remote-private flag low is granted in the same cycle without the token, when the core is not in serial mode and not at a quantum end.
- R3: A write to a line in Invalid or Shared state is granted only when the core holds the token and every other core is blocked.
- R4: A read of a line in Invalid or Shared state with the remote-private flag high is granted only when the core holds the token and every other core is blocked.
- R5: A core counts as blocked when its quantum-end flag is high or it has a pending access that needs the token (including the token holder); the all-blocked output is high exactly when every core is blocked.
- R6: An access that needs the token is never granted to a core without the token, even with every other core blocked.
- R7: From the cycle after a token-gated access is granted, every access of that core needs the token and every other core blocked, until the cycle after its quantum-end flag is seen high.
- R8: A core with its quantum-end flag high gets no grant; stall equals access valid and not grant, so grant and stall are never both high.
- R9: Reset (rst_n low at a clock edge) takes every core out of serial mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | NUM_CORES | Core has a memory access pending |
| acc_write | input | NUM_CORES | Pending access is a write (1) or read (0) |
| line_state | input | NUM_CORES x 2 | Local coherence state of the target line: 0 Invalid, 1 Shared, 2 Exclusive, 3 Modified |
| remote_priv | input | NUM_CORES | Another core holds the target line privately |
| token_held | input | NUM_CORES | Core holds the deterministic token (at most one bit set) |
| quantum_end | input | NUM_CORES | Core is blocked at the end of its quantum |
| grant | output | NUM_CORES | Access may proceed this cycle |
| stall | output | NUM_CORES | Access must wait |
| all_blocked | output | 1 | Every core is blocked |

## Verification
The sweeps go after the boundary between private and non-private states, where a design that tested the wrong state bit would let writes to shared lines race ahead or would stall private reads needlessly. They cover the token holder alone with every peer blocked but one, where a design that checked only the token would let a communicating access run while another thread still executes, and the reverse case of all peers blocked but no token. They also test that the holder itself is counted in the all-blocked output, and that serial mode survives idle cycles and ends only at the quantum boundary; a design that dropped serial mode early would let later private accesses of the suffix run in parallel.

// File: rtl/sgac_pkg.sv
// Shared types of the sharing-state gated access controller.
// Assumes a 2-bit local line state with the private states in the upper half.
package sgac_pkg;

    typedef enum logic [1:0] {
        LINE_INVALID   = 2'd0,
        LINE_SHARED    = 2'd1,
        LINE_EXCLUSIVE = 2'd2,
        LINE_MODIFIED  = 2'd3
    } line_state_e;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_FREE  = 2'd1,
        ACC_GATED = 2'd2
    } acc_class_e;

    // A line is private to its holder when it is Exclusive or Modified.
    function automatic logic line_is_private(input logic [1:0] st);
        return (st == LINE_EXCLUSIVE) || (st == LINE_MODIFIED);
    endfunction

endpackage

// File: rtl/sgac_access_classify.sv
// Classifies one core's pending access as idle, free (may run in the
// parallel prefix) or gated (needs token and all other cores blocked).
// Assumes line_state is the state after any miss has been serviced.
module sgac_access_classify
    import sgac_pkg::*;
(
    input  logic       acc_valid,
    input  logic       acc_write,
    input  logic [1:0] line_state,
    input  logic       remote_priv,
    input  logic       serial_mode,
    output acc_class_e acc_class
);

    // Decide the class of the access from sharing state and mode.
    always_comb begin
        if (!acc_valid) begin
            acc_class = ACC_IDLE;
        end else if (serial_mode) begin
            acc_class = ACC_GATED;
        end else if (line_is_private(line_state)) begin
            acc_class = ACC_FREE;
        end else if (acc_write || remote_priv) begin
            acc_class = ACC_GATED;
        end else begin
            acc_class = ACC_FREE;
        end
    end

endmodule

// File: rtl/sgac_block_detect.sv
// Reduces the per-core blocked flags into a global all-blocked flag and,
// for each core, a flag saying every other core is blocked.
// Assumes NUM_CORES >= 1.
module sgac_block_detect #(
    parameter int NUM_CORES = 4
) (
    input  logic [NUM_CORES-1:0] waiting,
    output logic                 all_blocked,
    output logic [NUM_CORES-1:0] others_blocked
);

    localparam logic [NUM_CORES-1:0] ONE = {{(NUM_CORES-1){1'b0}}, 1'b1};

    // Global reduction over every core.
    assign all_blocked = &waiting;

    // Per-core reduction that masks out the core itself.
    for (genvar gi = 0; gi < NUM_CORES; gi++) begin : g_others
        localparam logic [NUM_CORES-1:0] SELF = ONE << gi;
        assign others_blocked[gi] = &(waiting | SELF);
    end

endmodule

// File: rtl/sgac_serial_track.sv
// Holds one core's serial-mode flag: set when a token-gated access is
// granted, cleared when the core reaches its quantum end.
// Assumes the token is kept until the quantum end is signalled.
module sgac_serial_track (
    input  logic clk,
    input  logic rst_n,
    input  logic gated_grant,
    input  logic quantum_end,
    output logic serial_mode
);

    // Serial-mode state register with quantum end taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            serial_mode <= 1'b0;
        end else if (quantum_end) begin
            serial_mode <= 1'b0;
        end else if (gated_grant) begin
            serial_mode <= 1'b1;
        end
    end

    AST_SERIAL_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (gated_grant && !quantum_end) |=> serial_mode);                 // R7
    AST_SERIAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (serial_mode && !quantum_end) |=> serial_mode);                 // R7
    AST_SERIAL_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        quantum_end |=> !serial_mode);                                  // R7

endmodule

// File: rtl/sgac_gate_ctrl.sv
// Top of the sharing-state gated access controller. Per core it grants
// communication-free accesses at once and holds communicating accesses
// until the core has the token and every other core is blocked.
// Assumes at most one token_held bit is set and that a core with
// quantum_end high is waiting for the token, not issuing accesses.
module sgac_gate_ctrl
    import sgac_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_CORES-1:0]      acc_valid,
    input  logic [NUM_CORES-1:0]      acc_write,
    input  logic [NUM_CORES-1:0][1:0] line_state,
    input  logic [NUM_CORES-1:0]      remote_priv,
    input  logic [NUM_CORES-1:0]      token_held,
    input  logic [NUM_CORES-1:0]      quantum_end,
    output logic [NUM_CORES-1:0]      grant,
    output logic [NUM_CORES-1:0]      stall,
    output logic                      all_blocked
);

    acc_class_e             acc_class [NUM_CORES];
    logic [NUM_CORES-1:0]   waiting;
    logic [NUM_CORES-1:0]   others_blocked;
    logic [NUM_CORES-1:0]   serial_mode;
    logic [NUM_CORES-1:0]   gated_grant;

    // Global blocked detection shared by all cores.
    sgac_block_detect #(.NUM_CORES(NUM_CORES)) block_i (
        .waiting        (waiting),
        .all_blocked    (all_blocked),
        .others_blocked (others_blocked)
    );

    for (genvar gc = 0; gc < NUM_CORES; gc++) begin : g_core
        logic is_gated;
        logic is_free;

        // Classify this core's pending access.
        sgac_access_classify class_i (
            .acc_valid   (acc_valid[gc]),
            .acc_write   (acc_write[gc]),
            .line_state  (line_state[gc]),
            .remote_priv (remote_priv[gc]),
            .serial_mode (serial_mode[gc]),
            .acc_class   (acc_class[gc])
        );

        // Decode the class once for the grant and blocked logic.
        assign is_gated = (acc_class[gc] == ACC_GATED);
        assign is_free  = (acc_class[gc] == ACC_FREE);

        // A core is blocked at its quantum end or on a gated access.
        assign waiting[gc] = quantum_end[gc] | is_gated;

        // Grant free accesses now, gated ones with token and peers blocked.
        assign grant[gc] = !quantum_end[gc] &
                           (is_free | (is_gated & token_held[gc] & others_blocked[gc]));

        // Stall any pending access that is not granted.
        assign stall[gc] = acc_valid[gc] & ~grant[gc];

        // Mark the grants that move the core into serial mode.
        assign gated_grant[gc] = grant[gc] & is_gated;

        // Track the serial suffix of this core's quantum.
        sgac_serial_track serial_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .gated_grant (gated_grant[gc]),
            .quantum_end (quantum_end[gc]),
            .serial_mode (serial_mode[gc])
        );

        AST_GATED_NEEDS_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
            gated_grant[gc] |-> token_held[gc]);                        // R6
        AST_GATED_ALL_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
            gated_grant[gc] |-> all_blocked);                           // R3
        AST_QEND_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
            quantum_end[gc] |-> !grant[gc]);                            // R8
        AST_GRANT_STALL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
            !(grant[gc] && stall[gc]));                                 // R8
        AST_PRIVATE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_valid[gc] && line_state[gc][1] && !serial_mode[gc] && !quantum_end[gc])
            |-> grant[gc]);                                             // R1
        AST_BLOCKED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
            all_blocked |-> (acc_valid[gc] || quantum_end[gc]));        // R5
    end

    AST_TOKEN_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(token_held));                                          // R6

endmodule

// File: tb/sgac_gate_ctrl_tb_top.sv
module sgac_gate_ctrl_tb_top;

    localparam int NC = 4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NC-1:0]      acc_valid = '0;
    logic [NC-1:0]      acc_write = '0;
    logic [NC-1:0][1:0] line_state = '0;
    logic [NC-1:0]      remote_priv = '0;
    logic [NC-1:0]      token_held = '0;
    logic [NC-1:0]      quantum_end = '0;
    logic [NC-1:0]      grant;
    logic [NC-1:0]      stall;
    logic               all_blocked;

    int checks = 0;
    int errors = 0;
    logic [NC-1:0] mdl_serial = '0;
    logic [NC-1:0] exp_grant;
    logic [NC-1:0] exp_gated;
    logic          exp_allb;
    logic [31:0]   lfsr = 32'h1234_5678;

    sgac_gate_ctrl #(.NUM_CORES(NC)) dut_i (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .line_state(line_state), .remote_priv(remote_priv), .token_held(token_held),
        .quantum_end(quantum_end), .grant(grant), .stall(stall),
        .all_blocked(all_blocked)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    // Expected values from the requirements and the bench's own mode model.
    task automatic compute_expected();
        logic [NC-1:0] blk;
        for (int i = 0; i < NC; i++) begin
            logic priv;
            priv = (line_state[i] >= 2'd2);
            exp_gated[i] = acc_valid[i] &&
                           (mdl_serial[i] || (!priv && (acc_write[i] || remote_priv[i])));
            blk[i] = quantum_end[i] || exp_gated[i];
        end
        exp_allb = (blk == {NC{1'b1}});
        for (int i = 0; i < NC; i++) begin
            logic peers;
            peers = 1'b1;
            for (int j = 0; j < NC; j++) if (j != i && !blk[j]) peers = 1'b0;
            exp_grant[i] = acc_valid[i] && !quantum_end[i] &&
                           (!exp_gated[i] || (token_held[i] && peers));
        end
    endtask

    function automatic string tag_of(input int i);
        if (quantum_end[i]) return "R8";
        if (mdl_serial[i]) return "R7";
        if (line_state[i] >= 2'd2) return "R1";
        if (exp_gated[i] && !token_held[i]) return "R6";
        if (acc_write[i]) return "R3";
        if (remote_priv[i]) return "R4";
        return "R2";
    endfunction

    // Inputs are set at the falling edge; check, then advance the model.
    task automatic step();
        #1;
        compute_expected();
        for (int i = 0; i < NC; i++) begin
            chk(tag_of(i), $sformatf("grant[%0d]", i), grant[i], exp_grant[i]);
            chk("R8", $sformatf("stall[%0d]", i), stall[i], acc_valid[i] && !exp_grant[i]);
        end
        chk("R5", "all_blocked", all_blocked, exp_allb);
        @(posedge clk);
        for (int i = 0; i < NC; i++) begin
            if (quantum_end[i]) mdl_serial[i] = 1'b0;
            else if (exp_grant[i] && exp_gated[i]) mdl_serial[i] = 1'b1;
        end
        @(negedge clk);
    endtask

    task automatic clear_inputs();
        acc_valid = '0; acc_write = '0; line_state = '0;
        remote_priv = '0; token_held = '0; quantum_end = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        mdl_serial = '0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        @(negedge clk);
        do_reset();

        // Reset state: idle outputs.
        #1;
        chk("R9", "grant idle", |grant, 1'b0);
        chk("R9", "stall idle", |stall, 1'b0);
        chk("R5", "all_blocked idle", all_blocked, 1'b0);
        @(negedge clk);

        // Sweep core 0 over op, state, remote flag, token owner, peer blocking.
        for (int wr = 0; wr < 2; wr++)
        for (int st = 0; st < 4; st++)
        for (int rp = 0; rp < 2; rp++)
        for (int tk = 0; tk < 3; tk++)
        for (int m = 0; m < 8; m++) begin
            clear_inputs();
            acc_valid[0] = 1'b1;
            acc_write[0] = wr[0];
            line_state[0] = st[1:0];
            remote_priv[0] = rp[0];
            if (tk == 1) token_held[0] = 1'b1;
            if (tk == 2) token_held[1] = 1'b1;
            quantum_end[3:1] = m[2:0];
            step();
            // End the quantum to leave serial mode before the next case.
            clear_inputs();
            quantum_end[0] = 1'b1;
            step();
        end

        // Directed: serial mode persists until quantum end (R7).
        clear_inputs();
        acc_valid[0] = 1'b1; acc_write[0] = 1'b1; line_state[0] = 2'd1;
        token_held[0] = 1'b1; quantum_end[3:1] = 3'b111;
        step();
        clear_inputs(); token_held[0] = 1'b1;
        step();
        acc_valid[0] = 1'b1; line_state[0] = 2'd2;
        #1;
        chk("R7", "serial private read stalls", grant[0], 1'b0);
        @(negedge clk);
        quantum_end[1] = 1'b1; quantum_end[2] = 1'b1; quantum_end[3] = 1'b1;
        #1;
        chk("R7", "serial read with peers blocked", grant[0], 1'b1);
        @(negedge clk);
        clear_inputs(); quantum_end[0] = 1'b1;
        step();
        clear_inputs(); acc_valid[0] = 1'b1; line_state[0] = 2'd3;
        #1;
        chk("R7", "after quantum end private read free", grant[0], 1'b1);
        @(negedge clk);

        // Directed: reset leaves serial mode (R9).
        clear_inputs();
        acc_valid[0] = 1'b1; acc_write[0] = 1'b1; line_state[0] = 2'd0;
        token_held[0] = 1'b1; quantum_end[3:1] = 3'b111;
        step();
        clear_inputs();
        do_reset();
        acc_valid[0] = 1'b1; line_state[0] = 2'd2;
        #1;
        chk("R9", "private read free after reset", grant[0], 1'b1);
        @(negedge clk);

        // Mixed traffic on all cores from a deterministic shift register.
        for (int n = 0; n < 3000; n++) begin
            int tp;
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 17);
            lfsr = lfsr ^ (lfsr << 5);
            acc_valid   = lfsr[3:0] | lfsr[7:4];
            acc_write   = lfsr[11:8];
            line_state  = lfsr[19:12];
            remote_priv = lfsr[23:20];
            quantum_end = lfsr[27:24] & lfsr[31:28] & lfsr[7:4];
            tp = (n / 7) % 5;
            token_held = (tp < NC) ? (NC'(1) << tp) : '0;
            step();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule